// File: doc/BRIEF.md
# Sixteen-by-sixteen luma DC and plane predictor with early parameter preparation

This block generates the four whole-macroblock luma prediction modes (vertical, horizontal, DC and plane) one 4x4 slice at a time, four samples per clock. A caller first loads the 16 neighbours above the macroblock, the 16 neighbours to its left and the top-left corner sample. It then requests slices by giving a mode and the slice's column and row inside the macroblock. Each accepted slice comes out as four consecutive rows of four samples.

The DC average and the plane parameters take more arithmetic than one output cycle allows. A small parameter engine therefore works through them in five steps, using only the cycles in which the lane adders are free: idle cycles and the cycles that pass neighbours straight through for vertical or horizontal slices. When the caller issues at least one bypass slice first, the DC and plane slices start with no stall. Each of the four modes then costs four cycles per slice. A DC or plane request made before the parameters are ready waits until the last step finishes.

Top module: `intra16_dcplane`

## Requirements
- R1: After reset, `out_valid` is 0 and `req_ready` is 1.
- R2: In a vertical slice (mode code 0), lane i of every row equals top neighbour 4*col+i. Neighbour n sits in bits [8n+7:8n] of `top_nb` (and of `left_nb`).
- R3: In a horizontal slice (mode code 1), every lane of slice row r equals left neighbour 4*row+r.
- R4: In a DC slice (mode code 2), every sample equals (sum of the 16 top and 16 left neighbours + 16) >> 5.
- R5: In a plane slice (mode code 3), the sample at macroblock position (x,y) = (4*col+lane, 4*row+line) is (a + b*(x-7) + c*(y-7) + 16) >> 5 (arithmetic shift). Here a = 16*(top15+left15), b = (5H+32)>>6 and c = (5V+32)>>6. H is the sum over k=0..7 of (k+1)*(top[8+k]-top[6-k]), with top[-1] taken as the corner sample. V is formed the same way from the left column and the corner.
- R6: A vertical or horizontal slice accepted at a clock edge drives `out_valid` high for exactly the next four cycles. Its rows come top to bottom, with lane 0 in `out_pix[7:0]`. `req_ready` is high during the final row, so a following slice continues with no gap.
- R7: `nb_load` restarts a five-step parameter phase. One step completes in every cycle that is not a DC or plane output cycle. A DC or plane slice requested just after the load cycle therefore starts after a four-cycle stall. Once the phase completes, the parameters hold until the next load, and DC and plane slices start with no stall, including directly after a bypass slice.
- R8: Plane results below zero come out as 0, and results above 255 come out as 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nb_load | input | 1 | Capture neighbours and restart the parameter phase |
| top_nb | input | 128 | Sixteen top neighbours, neighbour n in bits [8n+7:8n] |
| left_nb | input | 128 | Sixteen left neighbours, same packing |
| corner_nb | input | 8 | Top-left corner sample |
| req_valid | input | 1 | Slice request present |
| req_mode | input | 2 | 0 vertical, 1 horizontal, 2 DC, 3 plane |
| req_col | input | 2 | Slice column inside the macroblock |
| req_row | input | 2 | Slice row inside the macroblock |
| req_ready | output | 1 | Request is taken at this edge when valid |
| out_valid | output | 1 | `out_pix` holds one slice row |
| out_pix | output | 32 | Four predicted samples, lane 0 in the low byte |

## Verification
The bench builds the block with its default 8-bit sample width. It sweeps all sixteen slices in every mode for six neighbour sets: pseudo-random values, all-zero, all-maximum, rising and falling ramps, and a mixed ramp. The steep ramps drive the plane sum beyond both ends of the sample range. Alternate neighbour sets begin with a bypass slice or with a cold DC or plane request. This exercises both the zero-stall handover and the four-cycle wait of the parameter phase.

// File: rtl/intra16_pkg.sv
package intra16_pkg;
  localparam int NB        = 16;
  localparam int LANES     = 4;
  localparam int PRE_STEPS = 5;

  typedef enum logic [1:0] {
    PM_VERT  = 2'd0,
    PM_HORZ  = 2'd1,
    PM_DC    = 2'd2,
    PM_PLANE = 2'd3
  } pmode_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_RUN  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/intra16_param_eng.sv
module intra16_param_eng
  import intra16_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int SUM_W = PIX_W + 6,
  localparam int HV_W  = PIX_W + 7,
  localparam int BC_W  = PIX_W + 4,
  localparam int A_W   = PIX_W + 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    hold,
  input  logic [PIX_W-1:0]        top_q  [NB],
  input  logic [PIX_W-1:0]        left_q [NB],
  input  logic [PIX_W-1:0]        corner_q,
  output logic                    params_ok,
  output logic                    params_done,
  output logic [PIX_W-1:0]        dc_val,
  output logic signed [A_W-1:0]   pa,
  output logic signed [BC_W-1:0]  pb,
  output logic signed [BC_W-1:0]  pc
);
  logic [2:0]              step_q, step_d;
  logic                    step_en;
  logic [SUM_W-1:0]        sum_q, sum_d, top_sum, left_sum;
  logic signed [HV_W-1:0]  h_q, h_d, v_q, v_d, h_calc, v_calc;
  logic [PIX_W-1:0]        dc_q, dc_d;
  logic signed [A_W-1:0]   a_q, a_d;
  logic signed [BC_W-1:0]  b_q, b_d, c_q, c_d;
  logic [PIX_W-1:0]        tx [NB+1];
  logic [PIX_W-1:0]        lx [NB+1];
  logic signed [HV_W+3:0]  h5, v5;
  logic [PIX_W:0]          a_sum;

  assign step_en     = (step_q < 3'(PRE_STEPS)) && !hold;
  assign params_done = (step_q == 3'(PRE_STEPS));
  assign params_ok   = !restart && (params_done || (step_en && step_q == 3'(PRE_STEPS - 1)));

  // Neighbour columns extended by the corner at index 0.
  always_comb begin
    tx[0] = corner_q;
    lx[0] = corner_q;
    for (int i = 0; i < NB; i++) begin
      tx[i+1] = top_q[i];
      lx[i+1] = left_q[i];
    end
  end

  always_comb begin
    top_sum  = '0;
    left_sum = '0;
    for (int i = 0; i < NB; i++) begin
      top_sum  = top_sum  + SUM_W'(top_q[i]);
      left_sum = left_sum + SUM_W'(left_q[i]);
    end
  end

  always_comb begin
    h_calc = '0;
    v_calc = '0;
    for (int k = 0; k < 8; k++) begin
      h_calc = h_calc + HV_W'(k + 1) *
               (HV_W'($signed({1'b0, tx[9+k]})) - HV_W'($signed({1'b0, tx[7-k]})));
      v_calc = v_calc + HV_W'(k + 1) *
               (HV_W'($signed({1'b0, lx[9+k]})) - HV_W'($signed({1'b0, lx[7-k]})));
    end
  end

  assign h5    = ((HV_W+4)'(h_q) <<< 2) + (HV_W+4)'(h_q) + (HV_W+4)'(32);
  assign v5    = ((HV_W+4)'(v_q) <<< 2) + (HV_W+4)'(v_q) + (HV_W+4)'(32);
  assign a_sum = {1'b0, top_q[NB-1]} + {1'b0, left_q[NB-1]};

  always_comb begin
    step_d = step_q;
    sum_d  = sum_q;
    h_d    = h_q;
    v_d    = v_q;
    dc_d   = dc_q;
    a_d    = a_q;
    b_d    = b_q;
    c_d    = c_q;
    if (restart) begin
      step_d = '0;
    end else if (step_en) begin
      step_d = step_q + 3'd1;
      case (step_q)
        3'd0: sum_d = top_sum;
        3'd1: sum_d = sum_q + left_sum;
        3'd2: h_d   = h_calc;
        3'd3: v_d   = v_calc;
        default: begin
          dc_d = PIX_W'((sum_q + SUM_W'(16)) >> 5);
          b_d  = BC_W'(h5 >>> 6);
          c_d  = BC_W'(v5 >>> 6);
          a_d  = $signed({1'b0, a_sum, 4'b0000});
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      sum_q  <= '0;
      h_q    <= '0;
      v_q    <= '0;
      dc_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
    end else begin
      step_q <= step_d;
      sum_q  <= sum_d;
      h_q    <= h_d;
      v_q    <= v_d;
      dc_q   <= dc_d;
      a_q    <= a_d;
      b_q    <= b_d;
      c_q    <= c_d;
    end
  end

  assign dc_val = dc_q;
  assign pa     = a_q;
  assign pb     = b_q;
  assign pc     = c_q;

  // R7
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= 3'(PRE_STEPS));
  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !restart) |=> $stable(step_q));
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (params_done && !restart) |=> params_done);
endmodule

// File: rtl/intra16_slice_seq.sv
module intra16_slice_seq
  import intra16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic [1:0] req_col,
  input  logic [1:0] req_row,
  input  logic       params_ok,
  output logic       req_ready,
  output logic       run,
  output logic       heavy_run,
  output pmode_t     cur_mode,
  output logic [1:0] cur_col,
  output logic [1:0] cur_row,
  output logic [1:0] cur_line
);
  sq_state_t  state_q, state_d;
  pmode_t     mode_q, mode_d;
  logic [1:0] col_q, col_d, row_q, row_d, line_q, line_d;
  logic       last, accept;

  assign last      = (state_q == SQ_RUN) && (line_q == 2'd3);
  assign req_ready = (state_q == SQ_IDLE) || last;
  assign accept    = req_valid && req_ready;
  assign run       = (state_q == SQ_RUN);
  assign heavy_run = run && (mode_q == PM_DC || mode_q == PM_PLANE);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    col_d   = col_q;
    row_d   = row_q;
    line_d  = line_q;
    case (state_q)
      SQ_WAIT: if (params_ok) begin
        state_d = SQ_RUN;
        line_d  = 2'd0;
      end
      SQ_RUN: begin
        if (last) state_d = SQ_IDLE;
        else      line_d  = line_q + 2'd1;
      end
      default: ;
    endcase
    if (accept) begin
      mode_d  = pmode_t'(req_mode);
      col_d   = req_col;
      row_d   = req_row;
      line_d  = 2'd0;
      state_d = (!req_mode[1] || params_ok) ? SQ_RUN : SQ_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= PM_VERT;
      col_q   <= '0;
      row_q   <= '0;
      line_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      col_q   <= col_d;
      row_q   <= row_d;
      line_q  <= line_d;
    end
  end

  assign cur_mode = mode_q;
  assign cur_col  = col_q;
  assign cur_row  = row_q;
  assign cur_line = line_q;

  // R6
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_q != 2'd3) |=> (run && line_q == $past(line_q) + 2'd1));
  // R6
  bypass_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_mode[1]) |=> (run && line_q == 2'd0));
endmodule

// File: rtl/intra16_lane.sv
module intra16_lane
  import intra16_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANE  = 0,
  localparam int BC_W = PIX_W + 4,
  localparam int A_W  = PIX_W + 6,
  localparam int PL_W = PIX_W + 12
) (
  input  pmode_t                  mode,
  input  logic [1:0]              col,
  input  logic [1:0]              row,
  input  logic [1:0]              line,
  input  logic [PIX_W-1:0]        top_q  [NB],
  input  logic [PIX_W-1:0]        left_q [NB],
  input  logic [PIX_W-1:0]        dc_val,
  input  logic signed [A_W-1:0]   pa,
  input  logic signed [BC_W-1:0]  pb,
  input  logic signed [BC_W-1:0]  pc,
  output logic [PIX_W-1:0]        pix
);
  localparam logic [1:0] LIDX = 2'(LANE);
  logic [3:0]             x_pos, y_pos;
  logic signed [5:0]      x_off, y_off;
  logic signed [PL_W-1:0] pl_sum, pl_shift;
  logic [PIX_W-1:0]       pl_clip;

  assign x_pos  = {col, LIDX};
  assign y_pos  = {row, line};
  assign x_off  = $signed({2'b00, x_pos}) - 6'sd7;
  assign y_off  = $signed({2'b00, y_pos}) - 6'sd7;
  assign pl_sum = PL_W'(pa) + PL_W'(pb) * PL_W'(x_off) + PL_W'(pc) * PL_W'(y_off) + PL_W'(16);
  assign pl_shift = pl_sum >>> 5;

  always_comb begin
    if (pl_shift < 0)
      pl_clip = '0;
    else if (pl_shift > PL_W'((1 << PIX_W) - 1))
      pl_clip = '1;
    else
      pl_clip = pl_shift[PIX_W-1:0];
  end

  always_comb begin
    case (mode)
      PM_VERT:  pix = top_q[x_pos];
      PM_HORZ:  pix = left_q[y_pos];
      PM_DC:    pix = dc_val;
      default:  pix = pl_clip;
    endcase
  end
endmodule

// File: rtl/intra16_dcplane.sv
module intra16_dcplane
  import intra16_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int BC_W = PIX_W + 4,
  localparam int A_W  = PIX_W + 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     nb_load,
  input  logic [NB*PIX_W-1:0]      top_nb,
  input  logic [NB*PIX_W-1:0]      left_nb,
  input  logic [PIX_W-1:0]         corner_nb,
  input  logic                     req_valid,
  input  logic [1:0]               req_mode,
  input  logic [1:0]               req_col,
  input  logic [1:0]               req_row,
  output logic                     req_ready,
  output logic                     out_valid,
  output logic [LANES*PIX_W-1:0]   out_pix
);
  logic [PIX_W-1:0]       top_q  [NB];
  logic [PIX_W-1:0]       left_q [NB];
  logic [PIX_W-1:0]       corner_q, dc_val;
  logic                   params_ok, params_done, heavy_run;
  logic signed [A_W-1:0]  pa;
  logic signed [BC_W-1:0] pb, pc;
  pmode_t                 cur_mode;
  logic [1:0]             cur_col, cur_row, cur_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corner_q <= '0;
      for (int i = 0; i < NB; i++) begin
        top_q[i]  <= '0;
        left_q[i] <= '0;
      end
    end else if (nb_load) begin
      corner_q <= corner_nb;
      for (int i = 0; i < NB; i++) begin
        top_q[i]  <= top_nb[i*PIX_W +: PIX_W];
        left_q[i] <= left_nb[i*PIX_W +: PIX_W];
      end
    end
  end

  intra16_param_eng #(.PIX_W(PIX_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .restart(nb_load), .hold(heavy_run),
    .top_q(top_q), .left_q(left_q), .corner_q(corner_q),
    .params_ok(params_ok), .params_done(params_done),
    .dc_val(dc_val), .pa(pa), .pb(pb), .pc(pc)
  );

  intra16_slice_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_col(req_col), .req_row(req_row), .params_ok(params_ok),
    .req_ready(req_ready), .run(out_valid), .heavy_run(heavy_run),
    .cur_mode(cur_mode), .cur_col(cur_col), .cur_row(cur_row), .cur_line(cur_line)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    intra16_lane #(.PIX_W(PIX_W), .LANE(g)) u_lane (
      .mode(cur_mode), .col(cur_col), .row(cur_row), .line(cur_line),
      .top_q(top_q), .left_q(left_q), .dc_val(dc_val),
      .pa(pa), .pb(pb), .pc(pc), .pix(out_pix[g*PIX_W +: PIX_W])
    );
  end

  // R7
  heavy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    heavy_run |-> params_done);
endmodule

// File: tb/intra16_dcplane_test.sv
module intra16_dcplane_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         nb_load;
  logic [127:0] top_nb, left_nb;
  logic [7:0]   corner_nb;
  logic         req_valid;
  logic [1:0]   req_mode, req_col, req_row;
  logic         req_ready, out_valid;
  logic [31:0]  out_pix;

  int tv[16];
  int lv[16];
  int cv;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  intra16_dcplane uut (
    .clk(clk), .rst_n(rst_n), .nb_load(nb_load), .top_nb(top_nb),
    .left_nb(left_nb), .corner_nb(corner_nb), .req_valid(req_valid),
    .req_mode(req_mode), .req_col(req_col), .req_row(req_row),
    .req_ready(req_ready), .out_valid(out_valid), .out_pix(out_pix)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  function automatic int clip8(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic int plane_raw(int x, int y);
    int h = 0, v = 0, a, b, c, lo;
    for (int k = 0; k < 8; k++) begin
      lo = (k == 7) ? cv : tv[6-k];
      h += (k + 1) * (tv[8+k] - lo);
      lo = (k == 7) ? cv : lv[6-k];
      v += (k + 1) * (lv[8+k] - lo);
    end
    a = 16 * (tv[15] + lv[15]);
    b = (5 * h + 32) >>> 6;
    c = (5 * v + 32) >>> 6;
    return (a + b * (x - 7) + c * (y - 7) + 16) >>> 5;
  endfunction

  function automatic int ref_pix(int m, int x, int y);
    int s = 0;
    case (m)
      0: return tv[x];
      1: return lv[y];
      2: begin
        for (int i = 0; i < 16; i++) s += tv[i] + lv[i];
        return (s + 16) >> 5;
      end
      default: return clip8(plane_raw(x, y));
    endcase
  endfunction

  task automatic set_pattern(int kind);
    logic [31:0] s = 32'h1234_5677 + 32'(kind);
    for (int i = 0; i < 16; i++) begin
      case (kind)
        0: begin
          s = s * 32'd1103515245 + 32'd12345;
          tv[i] = int'((s >> 16) & 32'hff);
          s = s * 32'd1103515245 + 32'd12345;
          lv[i] = int'((s >> 16) & 32'hff);
        end
        1: begin tv[i] = 0;   lv[i] = 0;   end
        2: begin tv[i] = 255; lv[i] = 255; end
        3: begin tv[i] = clip8(i * 17); lv[i] = clip8(i * 17); end
        4: begin tv[i] = 255 - i * 17;  lv[i] = 255 - i * 17;  end
        default: begin tv[i] = i * 16; lv[i] = 255 - i * 16; end
      endcase
    end
    case (kind)
      0: cv = 77;
      1: cv = 0;
      2: cv = 255;
      3: cv = 0;
      4: cv = 255;
      default: cv = 128;
    endcase
  endtask

  task automatic load_nb();
    for (int i = 0; i < 16; i++) begin
      top_nb[i*8 +: 8]  = 8'(tv[i]);
      left_nb[i*8 +: 8] = 8'(lv[i]);
    end
    corner_nb = 8'(cv);
    nb_load = 1'b1;
    @(negedge clk);
    nb_load = 1'b0;
  endtask

  task automatic run_slice(int m, int bx, int by, int exp_stall);
    int stall = 0;
    int x, y, exp_v, act;
    req_mode  = 2'(m);
    req_col   = 2'(bx);
    req_row   = 2'(by);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!out_valid && stall < 20) begin
      stall++;
      @(negedge clk);
    end
    checks++;
    if (stall != exp_stall) begin
      failures++;
      if (m >= 2) $display("FAIL R7 stall mode %0d: actual %0d expected %0d", m, stall, exp_stall);
      else        $display("FAIL R6 stall mode %0d: actual %0d expected %0d", m, stall, exp_stall);
    end
    for (int line = 0; line < 4; line++) begin
      if (line > 0) @(negedge clk);
      checks++;
      if (!out_valid) begin
        failures++;
        $display("FAIL R6 row %0d valid: actual 0 expected 1", line);
      end
      for (int lane = 0; lane < 4; lane++) begin
        x = bx * 4 + lane;
        y = by * 4 + line;
        exp_v = ref_pix(m, x, y);
        act = int'(out_pix[lane*8 +: 8]);
        checks++;
        if (act != exp_v) begin
          failures++;
          case (m)
            0: $display("FAIL R2 (%0d,%0d): actual %0d expected %0d", x, y, act, exp_v);
            1: $display("FAIL R3 (%0d,%0d): actual %0d expected %0d", x, y, act, exp_v);
            2: $display("FAIL R4 (%0d,%0d): actual %0d expected %0d", x, y, act, exp_v);
            default:
              if (plane_raw(x, y) != exp_v)
                $display("FAIL R8 (%0d,%0d): actual %0d expected %0d", x, y, act, exp_v);
              else
                $display("FAIL R5 (%0d,%0d): actual %0d expected %0d", x, y, act, exp_v);
          endcase
        end
      end
    end
  endtask

  task automatic sweep(int m);
    for (int by = 0; by < 4; by++)
      for (int bx = 0; bx < 4; bx++)
        run_slice(m, bx, by, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    nb_load = 1'b0;
    req_valid = 1'b0;
    req_mode = '0;
    req_col = '0;
    req_row = '0;
    top_nb = '0;
    left_nb = '0;
    corner_nb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || req_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset: actual valid=%0b ready=%0b expected valid=0 ready=1",
               out_valid, req_ready);
    end
    for (int kind = 0; kind < 6; kind++) begin
      set_pattern(kind);
      load_nb();
      if (kind % 2 == 0) begin
        // R7: bypass slices cover the parameter phase, DC follows without stall
        sweep(0);
        sweep(2);
      end else begin
        // R7: cold heavy request waits four cycles after the load
        run_slice((kind == 3) ? 3 : 2, 1, 2, 4);
        sweep(0);
        sweep(2);
      end
      sweep(1);
      sweep(3);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule